// File: doc/BRIEF.md
# Tapped Binary Divider Chain

The block is a fourteen-stage binary divider that advances once on every falling edge of its clock input. Each stage runs at half the rate of the stage below it, so stage n completes one period every 2^n input clocks. Only a subset of the stages leaves the block as taps; the lowest three stages and stage eleven stay internal.

A high level on the reset input clears every stage at once, without a clock edge, and pulls the oscillator-enable output low so that the external oscillator driving the clock can be stopped in standby. The release of reset is retimed to the falling clock edge by a short synchronizer, so the first count after reset always lands on the same edge. Every stage is a register on the one clock, so all taps change together right after a falling edge. A strobe output, high only during the low clock phase while counting is enabled, lets a downstream decoder sample tap combinations while they are steady.

Top module: `tapped_divider`

## Requirements
- R1: While the reset input is high, every tap is low, and raising reset clears the taps at once, without waiting for a clock edge.
- R2: The oscillator-enable output is low whenever the reset input is high and high whenever it is low, with no clock edge involved.
- R3: After reset falls, the count holds at zero for SYNC_STAGES (default 2) falling edges and first steps to one on falling edge SYNC_STAGES+1. With the defaults, tap bit 0 (stage 4) first rises on the tenth falling edge after release.
- R4: Once counting is enabled, the internal count grows by exactly one on every falling clock edge, and the taps change only right after falling edges.
- R5: Stage n equals bit n-1 of the count. Tap bits 0 to 6 carry stages 4 to 10 in order, and tap bits 7 to 9 carry stages 12 to 14 in order.
- R6: A full cycle takes 16384 counts. Tap bit 9 (stage 14) rises when the count reaches 8192 and falls when it wraps from 16383 to 0.
- R7: The strobe output is high only while the clock is low and counting is enabled. It is low during reset, during the synchronizer delay and during every high clock phase.
- R8: A reset raised in the middle of a count returns every tap to zero and holds them there across falling edges. After release, counting restarts from zero with the timing of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock from the external oscillator; the count advances on its falling edge |
| rst_i | input | 1 | Active-high asynchronous reset; clears all stages and stops the oscillator |
| taps_o | output | 10 | Exposed stage outputs: bits 0-6 are stages 4-10, bits 7-9 are stages 12-14 |
| osc_en_o | output | 1 | Oscillator enable; low while reset is high |
| strobe_o | output | 1 | Decode strobe; high during the low clock phase while counting |

## Verification
Taps and strobe settle in the same falling edge that advances the count. The clear of the taps and the drop of the oscillator enable follow the reset level with no edge at all, and the first count follows release by SYNC_STAGES+1 falling edges. A reference model in the bench steps on each falling edge and queues the expected taps, strobe and enable. A monitor pops and compares them 1 ns later, in the low phase, where all three are steady. Directed checks sample the reset response half a nanosecond after reset is raised, and count falling edges from release to the first rise of stage 4 and to the rise and fall of stage 14.

// File: rtl/tapdiv_pkg.sv
package tapdiv_pkg;

  localparam int DIV_STAGES    = 14;
  localparam int DIV_TAP_FIRST = 4;
  localparam int DIV_TAP_SKIP  = 11;
  localparam int DIV_SYNC      = 2;

  // number of stages driven out: first..stages, minus the skipped one
  function automatic int tap_count(int stages, int first, int skip);
    int n;
    n = stages - first + 1;
    if (skip >= first && skip <= stages) n = n - 1;
    return n;
  endfunction

  // stage number (1-based) carried on tap bit idx
  function automatic int tap_stage(int idx, int first, int skip);
    int s;
    s = first + idx;
    if (skip >= first && s >= skip) s = s + 1;
    return s;
  endfunction

endpackage

// File: rtl/tapdiv_release_sync.sv
module tapdiv_release_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic run_o
);

  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_multi
      always_comb sync_d = {sync_q[DEPTH-2:0], 1'b1};
    end
  endgenerate

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign run_o = sync_q[DEPTH-1];

endmodule

// File: rtl/tapdiv_stage.sv
module tapdiv_stage (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tog_i,
  output logic q_o
);

  logic q_q;
  logic q_d;

  always_comb q_d = q_q ^ tog_i;

  always_ff @(negedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) q_q <= 1'b0;
    else          q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/tapdiv_chain.sv
module tapdiv_chain #(
  parameter int STAGES = 14
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              en_i,
  output logic [STAGES-1:0] count_o
);

  logic [STAGES-1:0] carry;

  assign carry[0] = en_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    tapdiv_stage u_stage (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .tog_i   (carry[k]),
      .q_o     (count_o[k])
    );
    if (k < STAGES - 1) begin : g_carry
      assign carry[k+1] = carry[k] & count_o[k];
    end
  end

endmodule

// File: rtl/tapdiv_tap_select.sv
module tapdiv_tap_select #(
  parameter int STAGES    = 14,
  parameter int TAP_FIRST = 4,
  parameter int TAP_SKIP  = 11,
  parameter int NTAPS     = 10
) (
  input  logic [STAGES-1:0] count_i,
  output logic [NTAPS-1:0]  taps_o
);

  logic unused_count;
  assign unused_count = ^count_i;

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    localparam int SRC = tapdiv_pkg::tap_stage(i, TAP_FIRST, TAP_SKIP);
    assign taps_o[i] = count_i[SRC-1];
  end

endmodule

// File: rtl/tapped_divider.sv
module tapped_divider
  import tapdiv_pkg::*;
#(
  parameter  int STAGES      = DIV_STAGES,
  parameter  int TAP_FIRST   = DIV_TAP_FIRST,
  parameter  int TAP_SKIP    = DIV_TAP_SKIP,
  parameter  int SYNC_STAGES = DIV_SYNC,
  localparam int NTAPS       = tap_count(STAGES, TAP_FIRST, TAP_SKIP)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [NTAPS-1:0] taps_o,
  output logic             osc_en_o,
  output logic             strobe_o
);

  logic              rst_n;
  logic              run;
  logic [STAGES-1:0] count;

  assign rst_n = ~rst_i;

  tapdiv_release_sync #(.DEPTH(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .run_o   (run)
  );

  tapdiv_chain #(.STAGES(STAGES)) u_chain (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .en_i    (run),
    .count_o (count)
  );

  tapdiv_tap_select #(
    .STAGES    (STAGES),
    .TAP_FIRST (TAP_FIRST),
    .TAP_SKIP  (TAP_SKIP),
    .NTAPS     (NTAPS)
  ) u_taps (
    .count_i (count),
    .taps_o  (taps_o)
  );

  // oscillator must keep running through the release synchronizer
  assign osc_en_o = rst_n;

  // taps are steady through the low phase that follows each update
  assign strobe_o = run & ~clk_i;

endmodule

// File: rtl/tapdiv_checker.sv
module tapdiv_checker #(
  parameter int STAGES    = 14,
  parameter int TAP_FIRST = 4,
  parameter int TAP_SKIP  = 11,
  parameter int NTAPS     = 10
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              run_i,
  input logic [STAGES-1:0] count_i,
  input logic [NTAPS-1:0]  taps_i,
  input logic              osc_en_i
);

  AST_RESET_CLEARS: assert property (@(posedge clk_i) rst_i |-> (taps_i == '0) && !osc_en_i) // R1
    else $error("reset did not clear taps or stop oscillator");

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(run_i) |-> (count_i - $past(count_i)) == STAGES'(1)) // R4
    else $error("count did not advance by one");

  AST_HOLD_BEFORE_RUN: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(run_i) |-> count_i == $past(count_i)) // R3
    else $error("count moved before release completed");

  AST_TOP_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(taps_i[NTAPS-1]) |-> $past(count_i[STAGES-2:0]) == '1) // R6
    else $error("top tap toggled without full carry");

  for (genvar i = 0; i < NTAPS; i++) begin : g_map
    localparam int SRC = tapdiv_pkg::tap_stage(i, TAP_FIRST, TAP_SKIP);
    AST_TAP_MAP: assert property (@(posedge clk_i) disable iff (rst_i)
      taps_i[i] == count_i[SRC-1]) // R5
      else $error("tap %0d does not follow its stage", i);
  end

endmodule

bind tapped_divider tapdiv_checker #(
  .STAGES    (STAGES),
  .TAP_FIRST (TAP_FIRST),
  .TAP_SKIP  (TAP_SKIP),
  .NTAPS     (NTAPS)
) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .run_i    (run),
  .count_i  (count),
  .taps_i   (taps_o),
  .osc_en_i (osc_en_o)
);

// File: tb/tb_tapped_divider.sv
`timescale 1ns/1ps
module tb_tapped_divider;

  localparam int SYNC = 2;

  logic       clk;
  logic       rst;
  logic [9:0] taps;
  logic       osc_en;
  logic       strobe;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  typedef struct packed {
    logic [9:0] taps;
    logic       strobe;
    logic       osc_en;
  } exp_t;

  exp_t exp_q[$];

  tapped_divider dut (
    .clk_i    (clk),
    .rst_i    (rst),
    .taps_o   (taps),
    .osc_en_o (osc_en),
    .strobe_o (strobe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] map_taps(logic [13:0] c);
    return {c[13], c[12], c[11], c[9:3]};
  endfunction

  // reference model / driver: one step per falling edge
  logic [13:0] ref_cnt;
  int          ref_sync;
  initial begin
    ref_cnt  = '0;
    ref_sync = 0;
    forever begin
      exp_t e;
      @(negedge clk);
      if (rst) begin
        ref_cnt  = '0;
        ref_sync = 0;
      end else if (ref_sync == SYNC) begin
        ref_cnt = ref_cnt + 14'd1;
      end else begin
        ref_sync = ref_sync + 1;
      end
      e.taps   = map_taps(ref_cnt);
      e.strobe = !rst && (ref_sync == SYNC);
      e.osc_en = !rst;
      exp_q.push_back(e);
    end
  end

  // monitor: compare 1 ns into the low phase
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R5", "taps",   32'(taps),   32'(e.taps));
        chk("R7", "strobe", 32'(strobe), 32'(e.strobe));
        chk("R2", "osc_en", 32'(osc_en), 32'(e.osc_en));
      end
    end
  end

  // strobe must be low in every high phase
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!done) chk("R7", "strobe high phase", 32'(strobe), 32'd0);
    end
  end

  task automatic release_and_time_q4(string req);
    int n;
    @(posedge clk);
    #1 rst = 1'b0;
    #0.5;
    chk("R2", "osc_en after release", 32'(osc_en), 32'd1);
    n = 0;
    do begin
      @(negedge clk);
      #1.5;
      n++;
    end while (taps[0] !== 1'b1 && n < 64);
    chk(req, "edges to first stage4 rise", 32'(n), 32'(SYNC + 8));
  endtask

  initial begin
    int n;
    rst = 1'b1;
    #1;
    chk("R1", "taps in reset", 32'(taps), 32'd0);
    chk("R2", "osc_en in reset", 32'(osc_en), 32'd0);
    chk("R7", "strobe in reset", 32'(strobe), 32'd0);
    repeat (4) @(negedge clk);
    #1.5;
    chk("R1", "taps held across edges", 32'(taps), 32'd0);

    // R3 first count timing, then R6 top stage timing
    release_and_time_q4("R3");
    n = SYNC + 8;
    while (taps[9] !== 1'b1 && n < 20000) begin
      @(negedge clk);
      #1.5;
      n++;
    end
    chk("R6", "edges to stage14 rise", 32'(n), 32'(SYNC + 8192));
    while (taps[9] !== 1'b0 && n < 40000) begin
      @(negedge clk);
      #1.5;
      n++;
    end
    chk("R6", "edges to stage14 fall", 32'(n), 32'(SYNC + 16384));
    chk("R6", "taps after wrap", 32'(taps), 32'd0);

    // R4 sustained run past the wrap
    repeat (3000) @(negedge clk);
    #1.5;
    chk("R4", "taps mid count", 32'(taps), 32'(map_taps(14'(3000))));

    // R8 reset in the middle of a count, raised in the high phase
    @(posedge clk);
    #1 rst = 1'b1;
    #0.5;
    chk("R1", "immediate clear", 32'(taps), 32'd0);
    chk("R2", "osc stop immediate", 32'(osc_en), 32'd0);
    repeat (5) @(negedge clk);
    #1.5;
    chk("R8", "taps held through edges", 32'(taps), 32'd0);
    chk("R8", "strobe low in reset", 32'(strobe), 32'd0);
    release_and_time_q4("R8");

    // reset raised in the low phase
    @(negedge clk);
    #1.5 rst = 1'b1;
    #0.5;
    chk("R1", "clear in low phase", 32'(taps), 32'd0);
    repeat (3) @(negedge clk);
    release_and_time_q4("R3");
    repeat (100) @(negedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule